// File: doc/BRIEF.md
# Randomly Paced Lamp Guessing Game

A small reaction game controller. Four lamp outputs sit beside four push-button inputs, and an extra lamp signals a wrong guess. While the game runs, exactly one of the four lamps is lit, and the lit position walks around the ring. The walk advances only on clocks where an internal pseudorandom pacer allows it, so each lamp stays lit for a random number of clocks. The player must press the button next to the lamp that is lit at the moment of the clock edge.

A correct single press ends the round in a hit state. A press of any other button, or of several buttons at once, ends it in a miss state, which lights the error lamp. In both end states the four ring lamps are dark. The machine waits there until every button is released, then restarts from the first lamp. The pacer is an 8-bit maximal-length shift register. A prescaler derived from the clock-rate parameters sets how often it shifts, and a build parameter can force the pacer to allow a step on every tick, which gives a fixed rotation rate.

Top module: `lamp_guess_game`

## Requirements
- R1: A clock edge with `rst_n` low puts the machine in the hit state: `lamp_o` = 0000 and `err_o` = 0. The pacer register is reloaded with its nonzero seed (default 8'h01).
- R2: The internal state codes are: first lamp 000, second 001, third 011, fourth 010, hit 100, miss 101. Every rotation step changes exactly one state bit. Codes 110 and 111 go to the first-lamp state on the next clock.
- R3: With no button pressed, the lit lamp (`lamp_o` one-hot, bit k = lamp k+1) moves bit0→bit1→bit2→bit3→bit0 by one position on each edge where the step enable is high, and holds otherwise.
- R4: The step enable is high when the two low bits of the pacer are both zero. The pacer shifts left on every prescaler tick and takes in the XOR of bits 7, 5, 4 and 3. With the default parameters it ticks every clock. With `FORCE_STEP`=1 the enable is high on every tick.
- R5: If, in a rotating state, only the button whose bit matches the lit lamp is pressed at an edge, the next state is hit: all lamps dark and `err_o` = 0.
- R6: If, in a rotating state, any other non-zero button pattern is present at an edge (a wrong single button or several buttons), the next state is miss: `err_o` = 1 and `lamp_o` = 0000.
- R7: Buttons are judged at every edge in a rotating state, whether or not the step enable is high.
- R8: In the hit or miss state the outputs hold while any button is down. On the first edge with all buttons released, the machine enters the first-lamp state (`lamp_o` = 0001).
- R9: The outputs are decoded from the state register alone. A button change between edges does not alter `lamp_o` or `err_o` until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Game clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_i | input | 4 | Button levels, bit k is the button beside lamp k+1 |
| lamp_o | output | 4 | Ring lamps, one-hot while rotating |
| err_o | output | 1 | Miss lamp |

## Verification
The assertions assume that the button inputs are already debounced and synchronous, hold a defined level for a whole clock, and change only away from the active edge. They also assume that reset is asserted at the start of the run. The bench drives buttons and reset only on falling edges and holds them until the next falling edge, so every rising edge sees stable, defined levels. The one exception is a deliberate mid-cycle button change used to probe the Moore outputs. That change happens well before the following rising edge, so it still stays inside these assumptions.

// File: rtl/lgg_pkg.sv
// Shared types for the lamp guessing game.
// Assumes exactly four ring lamps; the state codes are fixed so that
// the rotation steps form a single-bit-change sequence.
package lgg_pkg;

    localparam int NUM_LAMPS = 4;

    typedef enum logic [2:0] {
        ST_L1   = 3'b000,
        ST_L2   = 3'b001,
        ST_L3   = 3'b011,
        ST_L4   = 3'b010,
        ST_HIT  = 3'b100,
        ST_MISS = 3'b101
    } game_st_e;

    // Lamp pattern that belongs to a state; zero outside the ring.
    function automatic logic [NUM_LAMPS-1:0] lamp_mask(input game_st_e st);
        case (st)
            ST_L1:   return 4'b0001;
            ST_L2:   return 4'b0010;
            ST_L3:   return 4'b0100;
            ST_L4:   return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    // Successor of a ring state.
    function automatic game_st_e next_lit(input game_st_e st);
        case (st)
            ST_L1:   return ST_L2;
            ST_L2:   return ST_L3;
            ST_L3:   return ST_L4;
            default: return ST_L1;
        endcase
    endfunction

    function automatic logic is_ring(input game_st_e st);
        return (st == ST_L1) || (st == ST_L2) || (st == ST_L3) || (st == ST_L4);
    endfunction

endpackage

// File: rtl/lgg_pacer.sv
// Pseudorandom step pacer.
// A prescaler divides the clock down to the pacing tick; on each tick
// a Fibonacci shift register advances. The step enable is raised on a
// tick when the low MATCH_BITS of the register are zero, or on every
// tick when FORCE_STEP is set. Assumes SEED is nonzero.
module lgg_pacer #(
    parameter int          LFSR_W     = 8,
    parameter logic [7:0]  TAP_MASK   = 8'hB8,
    parameter logic [7:0]  SEED       = 8'h01,
    parameter int          MATCH_BITS = 2,
    parameter bit          FORCE_STEP = 1'b0,
    parameter int          CLK_HZ     = 12,
    parameter int          LAMP_HZ    = 4,
    parameter int          SPEEDUP    = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic step_o
);
    localparam int DIV = (CLK_HZ / (LAMP_HZ * SPEEDUP) < 1) ? 1
                         : CLK_HZ / (LAMP_HZ * SPEEDUP);

    logic              tick;
    logic [LFSR_W-1:0] shreg;
    logic              feedback;

    generate
        if (DIV <= 1) begin : g_no_div
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            // Count clocks between pacing ticks.
            always_ff @(posedge clk) begin
                if (!rst_n)                       cnt <= '0;
                else if (cnt == CW'(DIV - 1))     cnt <= '0;
                else                              cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == CW'(DIV - 1));
        end
    endgenerate

    assign feedback = ^(shreg & TAP_MASK[LFSR_W-1:0]);

    // Advance the shift register once per tick; reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     shreg <= SEED[LFSR_W-1:0];
        else if (tick)  shreg <= {shreg[LFSR_W-2:0], feedback};
    end

    generate
        if (FORCE_STEP) begin : g_fixed
            assign step_o = tick;
        end else begin : g_random
            assign step_o = tick && (shreg[MATCH_BITS-1:0] == '0);
        end
    endgenerate

    // R4: a maximal-length register never reaches the all-zero lock-up value.
    assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (shreg != '0));

    // R1: the seed is present right after a reset edge.
    assert_seed_load_R1: assert property (@(posedge clk)
        !rst_n |=> (shreg == SEED[LFSR_W-1:0]));

endmodule

// File: rtl/lgg_fsm.sv
// Game state register and next-state logic.
// Judges the buttons on every edge in a ring state, advances the ring
// only when step_i is high, and waits for full release in the end states.
// Assumes btn_i is synchronous and debounced.
module lgg_fsm
    import lgg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LAMPS-1:0] btn_i,
    input  logic                 step_i,
    output game_st_e             state_o
);
    game_st_e state, nxt;
    logic     any_btn;

    assign any_btn = |btn_i;

    // Choose the next state from the current state, buttons and pacer.
    always_comb begin
        nxt = state;
        case (state)
            ST_L1, ST_L2, ST_L3, ST_L4: begin
                if (any_btn)     nxt = (btn_i == lamp_mask(state)) ? ST_HIT : ST_MISS;
                else if (step_i) nxt = next_lit(state);
            end
            ST_HIT, ST_MISS: begin
                if (!any_btn)    nxt = ST_L1;
            end
            default:             nxt = ST_L1;
        endcase
    end

    // State register; reset lands in the hit state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HIT;
        else        state <= nxt;
    end

    assign state_o = state;

    // R1: reset edge leaves the machine in the hit state.
    assert_reset_hit_R1: assert property (@(posedge clk)
        !rst_n |=> (state == ST_HIT));

    // R2: a rotation step flips exactly one state bit.
    assert_gray_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ring(state) && !any_btn && step_i) |=> ($countones(state ^ $past(state)) == 1));

    // R3: without a step and without buttons the lit lamp holds.
    assert_hold_lamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ring(state) && !any_btn && !step_i) |=> $stable(state));

    // R5: the matching single button gives a hit.
    assert_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ring(state) && (btn_i == lamp_mask(state))) |=> (state == ST_HIT));

    // R6: any other pressed pattern gives a miss.
    assert_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ring(state) && any_btn && (btn_i != lamp_mask(state))) |=> (state == ST_MISS));

    // R8: end states hold while a button is down.
    assert_end_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_ring(state) && any_btn) |=> $stable(state));

    // R8: full release restarts the ring at the first lamp.
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_ring(state) && !any_btn) |=> (state == ST_L1));

endmodule

// File: rtl/lgg_decode.sv
// Moore output decoder: ring lamps and miss lamp from the state only.
module lgg_decode
    import lgg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  game_st_e             state_i,
    output logic [NUM_LAMPS-1:0] lamp_o,
    output logic                 err_o
);
    // Translate the state code into lamp levels.
    always_comb begin
        lamp_o = lamp_mask(state_i);
        err_o  = (state_i == ST_MISS);
    end

    // R9: at most one lamp of the five is lit at any time.
    assert_one_lamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lamp_o, err_o}));

endmodule

// File: rtl/lamp_guess_game.sv
// Top of the lamp guessing game: pacer, state machine and output decoder.
// Assumes debounced synchronous buttons and a synchronous active-low reset.
module lamp_guess_game
    import lgg_pkg::*;
#(
    parameter logic [7:0] SEED       = 8'h01,
    parameter bit         FORCE_STEP = 1'b0,
    parameter int         CLK_HZ     = 12,
    parameter int         LAMP_HZ    = 4,
    parameter int         SPEEDUP    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] btn_i,
    output logic [3:0] lamp_o,
    output logic       err_o
);
    logic     step;
    game_st_e state;

    lgg_pacer #(
        .LFSR_W     (8),
        .TAP_MASK   (8'hB8),
        .SEED       (SEED),
        .MATCH_BITS (2),
        .FORCE_STEP (FORCE_STEP),
        .CLK_HZ     (CLK_HZ),
        .LAMP_HZ    (LAMP_HZ),
        .SPEEDUP    (SPEEDUP)
    ) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_o (step)
    );

    lgg_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_i   (btn_i),
        .step_i  (step),
        .state_o (state)
    );

    lgg_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (state),
        .lamp_o  (lamp_o),
        .err_o   (err_o)
    );

endmodule

// File: tb/tb_lamp_guess_game.sv
// Scoreboard bench: the driver computes expected lamps for a random-paced
// and a fixed-paced copy and queues them; the monitor compares after edges.
module tb_lamp_guess_game;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] btn = 4'b0000;
    logic [3:0] lamp_r, lamp_f;
    logic       err_r, err_f;

    always #4 clk = ~clk;

    lamp_guess_game #(.FORCE_STEP(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .btn_i(btn), .lamp_o(lamp_r), .err_o(err_r));

    lamp_guess_game #(.FORCE_STEP(1'b1)) dut_fixed (
        .clk(clk), .rst_n(rst_n), .btn_i(btn), .lamp_o(lamp_f), .err_o(err_f));

    typedef struct {
        logic [3:0] lamp_r;
        logic       err_r;
        logic [3:0] lamp_f;
        logic       err_f;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;

    // Model: positions 0..3 are ring lamps, 4 hit, 5 miss.
    int         m_r = 4, m_f = 4;
    logic [7:0] m_lfsr = 8'h01;

    function automatic int model_next(int s, logic [3:0] b, logic en);
        if (s < 4) begin
            if (b != 4'b0000) return (b == (4'b0001 << s)) ? 4 : 5;
            return en ? ((s + 1) % 4) : s;
        end
        return (b == 4'b0000) ? 0 : s;
    endfunction

    function automatic logic [3:0] lamps_of(int s);
        return (s < 4) ? (4'b0001 << s) : 4'b0000;
    endfunction

    function automatic logic [7:0] lfsr_adv(logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Driver: one call per clock; drives at the falling edge and queues expectations.
    task automatic drive(logic rn, logic [3:0] b, string tag, bit probe_moore = 0);
        exp_t e;
        @(negedge clk);
        rst_n = rn;
        btn   = b;
        if (probe_moore) begin
            #1;
            // R9: outputs still reflect the state before the button change.
            check({tag, " R9 random"}, {lamp_r, err_r}, {lamps_of(m_r), m_r == 5});
            check({tag, " R9 fixed"},  {lamp_f, err_f}, {lamps_of(m_f), m_f == 5});
        end
        if (!rn) begin
            m_r = 4; m_f = 4; m_lfsr = 8'h01;
        end else begin
            m_r = model_next(m_r, b, m_lfsr[1:0] == 2'b00);
            m_f = model_next(m_f, b, 1'b1);
            m_lfsr = lfsr_adv(m_lfsr);
        end
        e.lamp_r = lamps_of(m_r); e.err_r = (m_r == 5);
        e.lamp_f = lamps_of(m_f); e.err_f = (m_f == 5);
        e.tag    = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare both copies shortly after every rising edge.
    always begin
        exp_t e;
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check({e.tag, " random"}, {lamp_r, err_r}, {e.lamp_r, e.err_r});
            check({e.tag, " fixed"},  {lamp_f, err_f}, {e.lamp_f, e.err_f});
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset state.
        drive(1'b0, 4'b0000, "R1 reset");
        drive(1'b0, 4'b1111, "R1 reset buttons ignored");
        // R8: release from the hit state starts the ring.
        drive(1'b1, 4'b0000, "R8 restart");
        // R2 R3 R4: free rotation, random and fixed pacing.
        for (int i = 0; i < 40; i++) drive(1'b1, 4'b0000, "R2 R3 R4 rotation");
        // R5: correct single press, then hold, then release.
        drive(1'b1, lamps_of(m_r < 4 ? m_r : 0), "R5 hit", 1);
        for (int i = 0; i < 3; i++) drive(1'b1, 4'b0001, "R8 hold");
        drive(1'b1, 4'b0000, "R8 release");
        for (int i = 0; i < 5; i++) drive(1'b1, 4'b0000, "R3 rotation");
        // R6: two buttons at once.
        drive(1'b1, 4'b0101, "R6 multi press");
        drive(1'b1, 4'b0100, "R8 miss hold");
        drive(1'b1, 4'b0000, "R8 miss release");
        // R6: wrong single button.
        drive(1'b1, (m_r < 4) ? lamps_of((m_r + 1) % 4) : 4'b0010, "R6 wrong press");
        drive(1'b1, 4'b0000, "R8 release");
        // R7: press while the random copy is held (enable low at this edge).
        for (int k = 0; k < 20; k++) begin
            if (m_r < 4 && m_lfsr[1:0] != 2'b00) begin
                drive(1'b1, lamps_of(m_r), "R7 press during hold");
                drive(1'b1, 4'b0000, "R8 release");
                break;
            end
            drive(1'b1, 4'b0000, "R3 wait");
        end
        // Mixed stimulus: mostly idle, sometimes right or wrong guesses.
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [3:0] b;
            r = $urandom_range(0, 9);
            if (r < 6)       b = 4'b0000;
            else if (r < 8)  b = (m_r < 4) ? lamps_of(m_r) : 4'b0000;
            else             b = 4'($urandom_range(1, 15));
            drive(1'b1, b, "R5 R6 R7 R8 mixed", (i % 97) == 0);
        end
        // R1: reset in the middle of a game.
        drive(1'b0, 4'b0000, "R1 mid-run reset");
        for (int i = 0; i < 8; i++) drive(1'b1, 4'b0000, "R4 reseeded rotation");
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule